// File: doc/BRIEF.md
# Multi-Lane Pixel Frame Serializer

This block turns a stream of parallel pixel words into serial bit streams. Each word holds 24 colour bits (red, green and blue, eight bits each) and the three video timing flags. The block adds an odd parity bit and two zero reserved bits to form a 30-bit frame. It then sends that frame over one, two or three lanes, at 30, 15 or 10 bits per lane per pixel.

Everything runs on one fast bit clock. An internal frame counter marks each pixel period and acts as the load strobe. Its limit is 30, 15 or 10, set by the active lane mode. The block also outputs a regenerated pixel-rate clock, for a receiver to use as a frame marker. Each lane has an enable flag that tells the line driver whether to drive the lane or leave it in high impedance.

A pixel word is sampled on the bit-clock edge that closes a frame. It is packed and shifted out during the frame that follows, so data latency is one pixel period.

Top module: `pix_lane_serializer`

## Requirements
- R1: With `link_sel` = 2'b00, lane 0 sends these 30 bits, one per bit clock: parity, red[7:0] MSB first, green[7:0] MSB first, blue[7:0] MSB first, vsync, hsync, den, 0, 0.
- R2: With `link_sel` = 2'b01, each lane sends 15 bits. Lane 0 sends parity, red[7:0], green[7:4], vsync, 0. Lane 1 sends 0, green[3:0], blue[7:0], hsync, den.
- R3: With `link_sel` = 2'b10, each lane sends 10 bits. Lane 0 sends parity, red[7:0], vsync. Lane 1 sends 0, green[7:0], hsync. Lane 2 sends 0, blue[7:0], den.
- R4: The parity bit is 1 when the 27 payload bits (colours, vsync, hsync, den) hold an even number of ones, and 0 otherwise. The reserved zeros are not counted.
- R5: `lane_en` bit i enables lane i. The enables are 3'b001 for 2'b00, 3'b011 for 2'b01, 3'b111 for 2'b10 and 3'b000 for the reserved code 2'b11. A disabled lane's data output is 0. The reserved code uses a 30-cycle frame.
- R6: `link_sel` and the pixel inputs are sampled only on the edge that closes a frame. Changes at any other time do not affect the outputs.
- R7: The frame length is N = 30, 15 or 10 bit clocks. `pclk_out` is high for the first ceil(N/2) bit clocks of each frame and low for the rest. Its rising edge falls on the same edge as the frame's first bit.
- R8: A word sampled at the end of one frame is sent, starting with its first bit, during the next frame.
- R9: In reset and in the 30 bit clocks after reset, all enables and lane data are 0 and the frame counter is in the 30-bit mode. The first sample of the inputs happens on the 30th bit-clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_sel | input | 2 | Lane mode: 00 one lane, 01 two lanes, 10 three lanes, 11 reserved |
| red | input | 8 | Red component of the pixel word |
| green | input | 8 | Green component of the pixel word |
| blue | input | 8 | Blue component of the pixel word |
| vsync | input | 1 | Vertical sync flag |
| hsync | input | 1 | Horizontal sync flag |
| den | input | 1 | Data-enable flag |
| pclk_out | output | 1 | Regenerated pixel-rate clock |
| lane_dat | output | 3 | Serial data, one bit per lane |
| lane_en | output | 3 | Drive enable, one bit per lane |

## Verification
Every result can be dated from the frame-closing edge. On that edge the new mode, the new enables and a high `pclk_out` take effect, and the first bit of the word sampled one frame earlier appears on the lanes. Bit j of a frame is valid between edge j and edge j+1.

The bench changes inputs only at falling edges. It drives the real word and mode just before a closing edge and random values on every other cycle. It compares all outputs at the falling edge after each rising edge, against frames built from the word it drove one frame earlier.

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    link_sel,
  input  logic [CW-1:0] red,
  input  logic [CW-1:0] green,
  input  logic [CW-1:0] blue,
  input  logic          vsync,
  input  logic          hsync,
  input  logic          den,
  output logic          pclk_out,
  output logic [2:0]    lane_dat,
  output logic [2:0]    lane_en
);

  localparam int PW   = 3*CW + 3;
  localparam int FW   = PW + 3;
  localparam int HW   = FW / 2;
  localparam int TW   = CW + 2;
  localparam int H    = CW / 2;
  localparam int CNTW = $clog2(FW);

  function automatic logic [CNTW:0] flen(input logic [1:0] m);
    case (m)
      2'b01:   return (CNTW+1)'(HW);
      2'b10:   return (CNTW+1)'(TW);
      default: return (CNTW+1)'(FW);
    endcase
  endfunction

  function automatic logic [2:0] en_of(input logic [1:0] m);
    case (m)
      2'b00:   return 3'b001;
      2'b01:   return 3'b011;
      2'b10:   return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  logic [CNTW-1:0] cnt;
  logic [1:0]      mode;
  logic [PW-1:0]   hold;
  logic [FW-1:0]   sr0;
  logic [HW-1:0]   sr1;
  logic [TW-1:0]   sr2;
  logic            clk_q;
  logic [2:0]      en_q;

  logic [CNTW:0]   len_c, len_n;
  logic [CNTW-1:0] last_c;
  logic [CNTW:0]   half_c;
  logic            at_end;

  assign len_c  = flen(mode);
  assign len_n  = flen(link_sel);
  assign last_c = CNTW'(len_c - (CNTW+1)'(1));
  assign half_c = (len_c + (CNTW+1)'(1)) >> 1;
  assign at_end = (cnt == last_c);

  logic [CW-1:0] h_r, h_g, h_b;
  logic          h_vs, h_hs, h_de, par;

  assign h_r  = hold[PW-1 -: CW];
  assign h_g  = hold[PW-1-CW -: CW];
  assign h_b  = hold[PW-1-2*CW -: CW];
  assign h_vs = hold[2];
  assign h_hs = hold[1];
  assign h_de = hold[0];
  assign par  = ~^hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mode  <= 2'b00;
      hold  <= '0;
      en_q  <= 3'b000;
      clk_q <= 1'b1;
    end else if (at_end) begin
      cnt   <= '0;
      mode  <= link_sel;
      hold  <= {red, green, blue, vsync, hsync, den};
      en_q  <= en_of(link_sel);
      clk_q <= 1'b1;
    end else begin
      cnt   <= cnt + CNTW'(1);
      clk_q <= (({1'b0, cnt} + (CNTW+1)'(1)) < half_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr0 <= '0;
      sr1 <= '0;
      sr2 <= '0;
    end else if (at_end) begin
      case (link_sel)
        2'b00: begin
          sr0 <= {par, hold, 2'b00};
          sr1 <= '0;
          sr2 <= '0;
        end
        2'b01: begin
          sr0 <= {par, h_r, h_g[CW-1 -: H], h_vs, 1'b0, {(FW-HW){1'b0}}};
          sr1 <= {1'b0, h_g[H-1:0], h_b, h_hs, h_de};
          sr2 <= '0;
        end
        2'b10: begin
          sr0 <= {par, h_r, h_vs, {(FW-TW){1'b0}}};
          sr1 <= {1'b0, h_g, h_hs, {(HW-TW){1'b0}}};
          sr2 <= {1'b0, h_b, h_de};
        end
        default: begin
          sr0 <= '0;
          sr1 <= '0;
          sr2 <= '0;
        end
      endcase
    end else begin
      sr0 <= sr0 << 1;
      sr1 <= sr1 << 1;
      sr2 <= sr2 << 1;
    end
  end

  assign pclk_out = clk_q;
  assign lane_en  = en_q;
  assign lane_dat = en_q & {sr2[TW-1], sr1[HW-1], sr0[FW-1]};

  AST_EN_NEST_1: assert property (@(posedge clk) disable iff (!rst_n) lane_en[1] |-> lane_en[0]); // R5
  AST_EN_NEST_2: assert property (@(posedge clk) disable iff (!rst_n) lane_en[2] |-> lane_en[1]); // R5
  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (at_end && link_sel == 2'b11) |=> (lane_en == 3'b000 && lane_dat == 3'b000)); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !at_end |=> $stable(lane_en)); // R6
  AST_CLK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pclk_out) |-> (cnt == '0)); // R7
  AST_CLK_HIGH_AT_START: assert property (@(posedge clk) disable iff (!rst_n) at_end |=> pclk_out); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= last_c); // R7

endmodule

// File: tb/tb_pix_lane_serializer.sv
module tb_pix_lane_serializer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] link_sel;
  logic [7:0] red, green, blue;
  logic       vsync, hsync, den;
  logic       pclk_out;
  logic [2:0] lane_dat, lane_en;

  always #2 clk = ~clk;

  pix_lane_serializer dut (
    .clk(clk), .rst_n(rst_n), .link_sel(link_sel),
    .red(red), .green(green), .blue(blue),
    .vsync(vsync), .hsync(hsync), .den(den),
    .pclk_out(pclk_out), .lane_dat(lane_dat), .lane_en(lane_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [26:0] prev_px;

  function automatic int nlen(input logic [1:0] ls);
    case (ls)
      2'b01:   return 15;
      2'b10:   return 10;
      default: return 30;
    endcase
  endfunction

  function automatic logic [2:0] exp_en(input logic [1:0] ls);
    case (ls)
      2'b00:   return 3'b001;
      2'b01:   return 3'b011;
      2'b10:   return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [29:0] lane_vec(input logic [26:0] px, input logic [1:0] ls, input int lane);
    logic [7:0] r, g, b;
    logic vs, hs, de, p;
    r = px[26:19]; g = px[18:11]; b = px[10:3];
    vs = px[2]; hs = px[1]; de = px[0];
    p = ((px == 27'd0) ? 1'b1 : ~(^px));
    case (ls)
      2'b00: return (lane == 0) ? {p, r, g, b, vs, hs, de, 2'b00} : 30'd0;
      2'b01: begin
        if (lane == 0) return {p, r, g[7:4], vs, 1'b0, 15'd0};
        if (lane == 1) return {1'b0, g[3:0], b, hs, de, 15'd0};
        return 30'd0;
      end
      2'b10: begin
        if (lane == 0) return {p, r, vs, 20'd0};
        if (lane == 1) return {1'b0, g, hs, 20'd0};
        return {1'b0, b, de, 20'd0};
      end
      default: return 30'd0;
    endcase
  endfunction

  task automatic drive(input logic [1:0] ls, input logic [26:0] px);
    link_sel = ls;
    {red, green, blue, vsync, hsync, den} = px;
  endtask

  task automatic chk(input logic [1:0] ls, input logic [26:0] px, input int j, input bit rst_frame);
    logic [2:0] e_en, e_dat;
    logic e_clk;
    string tag;
    int n;
    n = nlen(ls);
    e_en = rst_frame ? 3'b000 : exp_en(ls);
    for (int l = 0; l < 3; l++) begin
      logic [29:0] v;
      v = lane_vec(px, ls, l);
      e_dat[l] = rst_frame ? 1'b0 : v[29-j];
    end
    e_clk = (j < (n + 1) / 2);
    if (rst_frame) tag = "R9";
    else if (j == 0) tag = "R4 R8";
    else case (ls)
      2'b00: tag = "R1 R8";
      2'b01: tag = "R2 R8";
      2'b10: tag = "R3 R8";
      default: tag = "R5";
    endcase
    checks++;
    if (lane_en !== e_en) begin
      errors++;
      $display("FAIL %s R5 R6 lane_en bit %0d: actual %b expected %b", rst_frame ? "R9" : "", j, lane_en, e_en);
    end
    checks++;
    if (lane_dat !== e_dat) begin
      errors++;
      $display("FAIL %s lane_dat bit %0d mode %b: actual %b expected %b", tag, j, ls, lane_dat, e_dat);
    end
    checks++;
    if (pclk_out !== e_clk) begin
      errors++;
      $display("FAIL R7 pclk_out bit %0d mode %b: actual %b expected %b", j, ls, pclk_out, e_clk);
    end
  endtask

  // Drive the word and mode before the frame-closing edge; R6: random garbage mid-frame
  task automatic frame(input logic [1:0] ls, input logic [26:0] px);
    int n;
    n = nlen(ls);
    drive(ls, px);
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      @(negedge clk);
      chk(ls, prev_px, j, 1'b0);
      if (j < n - 1) drive(2'($urandom), 27'($urandom));
    end
    prev_px = px;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    drive(2'b10, 27'h7FFFFFF);
    prev_px = 27'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (lane_en !== 3'b000 || lane_dat !== 3'b000) begin
      errors++;
      $display("FAIL R9 in reset: actual en %b dat %b expected 000 000", lane_en, lane_dat);
    end
    rst_n = 1'b1;
    chk(2'b00, 27'd0, 0, 1'b1);
    for (int j = 1; j < 30; j++) begin
      @(posedge clk);
      @(negedge clk);
      chk(2'b00, 27'd0, j, 1'b1);
      drive(2'($urandom), 27'($urandom));
    end
    // directed corners: parity of all-zero and all-one, each mode, reserved, switches
    frame(2'b00, 27'd0);
    frame(2'b00, 27'h7FFFFFF);
    frame(2'b01, 27'h5A5A5A5);
    frame(2'b10, 27'h0000001);
    frame(2'b11, 27'h4000000);
    frame(2'b10, 27'h0000800);
    frame(2'b01, 27'h3C3C3C3);
    frame(2'b00, 27'h1234567);
    frame(2'b10, 27'h7FFFFFE);
    for (int k = 0; k < 40; k++) frame(2'($urandom), 27'($urandom));
    frame(2'b00, 27'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule